// File: doc/BRIEF.md
# Peripheral Clock-Stop Handshake Controller

This block sits between software and the clock gates of three peripheral domains: channel 0 is an external memory interface, channel 1 a USB controller and channel 2 a UART. A peripheral's clock can be stopped in the middle of a bus access. The access is then left unfinished and the bus can hang. To prevent this, each channel uses a request/acknowledge exchange before its clock may be gated off.

Software sets a channel's stop request in the control register. On the peripheral side, the block then refuses any new transaction, waits for the current one to drain, and raises an acknowledge. The acknowledge passes through a two-flop synchroniser and is read back from the control register.

Only after the acknowledge reads as set will a write to the gating register turn that clock off. A gate-off attempt made too early is refused and flagged. Restarting works in the reverse order: software first turns the clock back on, then withdraws the request. A request withdrawn while the clock is still off is refused and flagged. Each clock output comes from a latch-based gate, so it never glitches.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset, all stop requests and acknowledges read 0, the gating register reads 3'b111 (every clock running) and the error register reads 0.
- R2: The control register is at word address 0x1C3A. Channel i has its stop request at bit 2i and its acknowledge at bit 2i+1, so channel 0 uses bits 0 and 1. The gating register is at 0x1C3B, with bit i = 1 meaning clock i runs. The error register is at 0x1C3C. Read data appears one clock after the address is presented.
- R3: Acknowledge bits are read-only, and writes to them have no effect. An acknowledge rises only while its request is set and the peripheral's busy input is low.
- R4: While a channel's stop request is set, that channel's grant output stays low whatever its start input does. Other channels keep granting.
- R5: Writing 0 to gating bit i while acknowledge i reads 1 stops clock output i. Clock output i follows the gating bit from the next high phase of the clock.
- R6: Writing 0 to gating bit i while acknowledge i reads 0 leaves the clock running and sets sticky error bit i.
- R7: Writing 0 to the request bit of a channel whose clock is off leaves the request set and sets sticky error bit 3+i.
- R8: Once a request is cleared while its clock runs, its acknowledge returns to 0.
- R9: Writing 1 to an error bit clears it. Writing 0 leaves it unchanged, and nothing else clears it.
- R10: Every clock output is low whenever the source clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock and source of all peripheral clocks |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register word address |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Registered read data for reg_addr |
| periph_busy | input | 3 | Per-channel bus transaction in progress |
| periph_start | input | 3 | Per-channel new transaction request |
| periph_grant | output | 3 | Per-channel transaction accepted |
| periph_gclk | output | 3 | Per-channel gated clock |

## Verification
The assertions assume that a peripheral's busy input only rises for a transaction the block granted. They also assume that busy eventually falls, so an acknowledge stays meaningful once raised.

The stimulus keeps to these assumptions. It raises busy on a channel only before that channel's request, and drops it after a few cycles. It never presents start to a gated-off channel as a live transaction. Misordered software writes (an early gate-off, a withdrawn request while the clock is off) are driven on purpose. This exercises the refusal paths.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int unsigned NCH_DEF       = 3;
  localparam int unsigned ADDR_W_DEF    = 16;
  localparam int unsigned SYNC_DEF      = 2;
  localparam logic [15:0] CTRL_ADDR_DEF = 16'h1C3A;
  localparam logic [15:0] GATE_ADDR_DEF = 16'h1C3B;
  localparam logic [15:0] ERR_ADDR_DEF  = 16'h1C3C;
endpackage

// File: rtl/clkstop_hs_unit.sv
module clkstop_hs_unit #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic stop_req,
  input  logic busy,
  input  logic start,
  output logic grant,
  output logic ack_sync
);
  logic                   ack_p;
  logic [SYNC_STAGES-1:0] sync_q;

  // peripheral side: only advances while its clock is enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_p <= 1'b0;
    end else if (run) begin
      if (stop_req) ack_p <= ack_p | ~busy;
      else          ack_p <= 1'b0;
    end
  end

  // no new transaction once a stop has been asked for
  assign grant = start & ~stop_req;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], ack_p};
  end
  assign ack_sync = sync_q[SYNC_STAGES-1];

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_p) |-> ($past(stop_req) && !$past(busy))); // R3
  AST_ACK_DROPS_ON_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_p) |-> ($past(run) && !$past(stop_req))); // R8
endmodule

// File: rtl/clkstop_gate_cell.sv
module clkstop_gate_cell (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;

  always @(negedge clk) begin
    #1;
    AST_GCLK_LOW: assert (gclk == 1'b0); // R10
  end
endmodule

// File: rtl/clkstop_regs.sv
module clkstop_regs #(
  parameter int unsigned NCH       = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h1C3A,
  parameter logic [ADDR_W-1:0] GATE_ADDR = 16'h1C3B,
  parameter logic [ADDR_W-1:0] ERR_ADDR  = 16'h1C3C,
  localparam int unsigned DATA_W   = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    ack_s,
  output logic [NCH-1:0]    req,
  output logic [NCH-1:0]    gate_en,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] err;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ctrl, wr_gate, wr_err;

  assign wr_ctrl = we && (addr == CTRL_ADDR);
  assign wr_gate = we && (addr == GATE_ADDR);
  assign wr_err  = we && (addr == ERR_ADDR);

  always_comb begin
    rd_mux = '0;
    if (addr == CTRL_ADDR) begin
      for (int i = 0; i < NCH; i++) begin
        rd_mux[2*i]   = req[i];
        rd_mux[2*i+1] = ack_s[i];
      end
    end else if (addr == GATE_ADDR) begin
      rd_mux[NCH-1:0] = gate_en;
    end else if (addr == ERR_ADDR) begin
      rd_mux = err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req     <= '0;
      gate_en <= '1;
      err     <= '0;
      rdata   <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr_ctrl) begin
        for (int i = 0; i < NCH; i++) begin
          if (!wdata[2*i] && req[i] && !gate_en[i]) err[NCH+i] <= 1'b1;
          else                                      req[i]     <= wdata[2*i];
        end
      end
      if (wr_gate) begin
        for (int i = 0; i < NCH; i++) begin
          if (!wdata[i] && gate_en[i] && !ack_s[i]) err[i]     <= 1'b1;
          else                                      gate_en[i] <= wdata[i];
        end
      end
      if (wr_err) err <= err & ~wdata;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_GATE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
      $fell(gate_en[g]) |-> $past(ack_s[g])); // R6
    AST_REQ_HELD_GATED: assert property (@(posedge clk) disable iff (rst)
      !gate_en[g] |-> req[g]); // R7
  end
  for (genvar k = 0; k < DATA_W; k++) begin : g_err
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      $fell(err[k]) |-> $past(wr_err && wdata[k])); // R9
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned NCH         = NCH_DEF,
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = CTRL_ADDR_DEF,
  parameter logic [ADDR_W-1:0] GATE_ADDR = GATE_ADDR_DEF,
  parameter logic [ADDR_W-1:0] ERR_ADDR  = ERR_ADDR_DEF,
  localparam int unsigned DATA_W     = 2 * NCH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    periph_busy,
  input  logic [NCH-1:0]    periph_start,
  output logic [NCH-1:0]    periph_grant,
  output logic [NCH-1:0]    periph_gclk
);
  logic [NCH-1:0] req, gate_en, ack_s;

  clkstop_regs #(
    .NCH(NCH), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .GATE_ADDR(GATE_ADDR), .ERR_ADDR(ERR_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ack_s(ack_s), .req(req), .gate_en(gate_en), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    clkstop_hs_unit #(.SYNC_STAGES(SYNC_STAGES)) u_hs (
      .clk(clk), .rst(rst), .run(gate_en[g]), .stop_req(req[g]),
      .busy(periph_busy[g]), .start(periph_start[g]),
      .grant(periph_grant[g]), .ack_sync(ack_s[g])
    );
    clkstop_gate_cell u_gate (
      .clk(clk), .en(gate_en[g]), .gclk(periph_gclk[g])
    );
  end
endmodule

// File: tb/tb_clkstop_ctrl.sv
module tb_clkstop_ctrl;
  localparam logic [15:0] A_CTRL = 16'h1C3A;
  localparam logic [15:0] A_GATE = 16'h1C3B;
  localparam logic [15:0] A_ERR  = 16'h1C3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = 16'h0;
  logic [5:0]  reg_wdata = 6'h0;
  logic [5:0]  reg_rdata;
  logic [2:0]  busy = 3'b0, start = 3'b0, grant, gclk;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;

  // reference state
  logic [2:0] m_req, m_ackp, m_s1, m_s2, m_gate, m_lat;
  logic [5:0] m_err, m_rdata;

  always #4 clk = ~clk; // 125 MHz

  clkstop_ctrl dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_busy(busy),
    .periph_start(start), .periph_grant(grant), .periph_gclk(gclk)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [2:0] n_req, n_ackp, n_gate;
    logic [5:0] n_err, n_rd;
    if (rst) begin
      m_req = 0; m_ackp = 0; m_s1 = 0; m_s2 = 0; m_gate = 3'b111;
      m_lat = 3'b111; m_err = 0; m_rdata = 0;
      return;
    end
    n_req = m_req; n_gate = m_gate; n_err = m_err; n_ackp = m_ackp;
    n_rd = 0;
    if (reg_addr == A_CTRL)
      for (int i = 0; i < 3; i++) begin n_rd[2*i] = m_req[i]; n_rd[2*i+1] = m_s2[i]; end
    else if (reg_addr == A_GATE) n_rd = {3'b0, m_gate};
    else if (reg_addr == A_ERR)  n_rd = m_err;
    for (int i = 0; i < 3; i++)
      if (m_gate[i]) n_ackp[i] = m_req[i] ? (m_ackp[i] | ~busy[i]) : 1'b0;
    if (reg_we && reg_addr == A_CTRL)
      for (int i = 0; i < 3; i++)
        if (!reg_wdata[2*i] && m_req[i] && !m_gate[i]) n_err[3+i] = 1'b1;
        else n_req[i] = reg_wdata[2*i];
    if (reg_we && reg_addr == A_GATE)
      for (int i = 0; i < 3; i++)
        if (!reg_wdata[i] && m_gate[i] && !m_s2[i]) n_err[i] = 1'b1;
        else n_gate[i] = reg_wdata[i];
    if (reg_we && reg_addr == A_ERR) n_err = m_err & ~reg_wdata;
    m_lat = m_gate; m_s2 = m_s1; m_s1 = m_ackp; m_ackp = n_ackp;
    m_req = n_req; m_gate = n_gate; m_err = n_err; m_rdata = n_rd;
  endtask

  always @(posedge clk) begin
    model_step();
    #2;
    if (cmp_on && !done) begin
      chk("R2 rdata", reg_rdata, m_rdata);
      chk("R4 grant", grant, start & ~m_req);
      chk("R5 gclk high", gclk, m_lat);
    end
  end

  always @(negedge clk) begin
    #2;
    if (cmp_on && !done) chk("R10 gclk low", gclk, 0);
  end

  task automatic wr(logic [15:0] a, logic [5:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [5:0] v);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #2; v = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk); cmp_on = 1;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_GATE, v); chk("R1 gate", v, 6'h07);
    rd(A_ERR, v);  chk("R1 err", v, 0);
    // channel 0 stop while busy
    busy = 3'b001;
    wr(A_CTRL, 6'h01); idle(6);
    rd(A_CTRL, v); chk("R3 ack waits busy", v, 6'h01);
    start = 3'b011; @(posedge clk); #2;
    chk("R4 ch0 refused", grant[0], 0);
    chk("R4 ch1 granted", grant[1], 1);
    @(negedge clk); start = 0;
    wr(A_GATE, 6'h06); idle(2);
    rd(A_GATE, v); chk("R6 gate kept", v, 6'h07);
    rd(A_ERR, v);  chk("R6 err flag", v, 6'h01);
    @(posedge clk); #2; chk("R6 clock runs", gclk[0], 1);
    busy = 0; idle(6);
    rd(A_CTRL, v); chk("R3 ack set", v, 6'h03);
    wr(A_CTRL, 6'h0B); idle(1);
    rd(A_CTRL, v); chk("R3 ack write ignored", v, 6'h03);
    wr(A_GATE, 6'h06); idle(2);
    rd(A_GATE, v); chk("R5 gate off", v, 6'h06);
    @(posedge clk); #2; chk("R5 clock stopped", gclk[0], 0);
    wr(A_CTRL, 6'h00); idle(1);
    rd(A_CTRL, v); chk("R7 req held", v, 6'h03);
    rd(A_ERR, v);  chk("R7 order err", v, 6'h09);
    wr(A_ERR, 6'h01); rd(A_ERR, v); chk("R9 w1c bit0", v, 6'h08);
    wr(A_ERR, 6'h00); rd(A_ERR, v); chk("R9 write0 keeps", v, 6'h08);
    wr(A_ERR, 6'h08); rd(A_ERR, v); chk("R9 w1c bit3", v, 6'h00);
    // restart in order
    wr(A_GATE, 6'h07); wr(A_CTRL, 6'h00); idle(6);
    rd(A_CTRL, v); chk("R8 ack cleared", v, 6'h00);
    @(posedge clk); #2; chk("R5 clock back", gclk[0], 1);
    // channel 2 (UART)
    wr(A_CTRL, 6'h10); idle(6);
    rd(A_CTRL, v); chk("R2 ch2 bits", v, 6'h30);
    wr(A_GATE, 6'h03); idle(2);
    rd(A_GATE, v); chk("R5 ch2 off", v, 6'h03);
    @(negedge clk); #2; chk("R10 low phase", gclk, 0);
    rd(A_ERR, v); chk("R6 no error", v, 6'h00);
    idle(3);
    finish_run();
  end
endmodule